// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block holds time of day and calendar date in seven packed-BCD byte fields and steps them forward by one second each time a fixed number of timebase pulses has arrived. The timebase input is a one-cycle strobe from an upstream divider, and an internal prescaler counts `TICKS_PER_SEC` of those strobes to form the per-second advance. The clock runs in 24-hour format, and the date logic covers 28, 29, 30 and 31-day months. The two-digit year is read as 2000 plus its value, so every year value divisible by four is a leap year.

The host loads all seven fields in one cycle through a wide write port and reads them back from a registered read port. A load also restarts the sub-second prescaler, so the first advance after a load comes one full second later. The weekday is not a BCD number. It is a one-hot mask that rotates left on every day carry. Two single-cycle strobes, one for each second advance and one for each minute boundary, are meant for downstream interrupt logic.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, the read port shows 00:00:00, weekday mask 0x01, day 0x01, month 0x01, year 0x00, and both strobes are low.
- R2: The seconds field advances by one in BCD at the clock edge that takes the `TICKS_PER_SEC`-th `tb_tick` since the last second or load. `rd_data` shows the new value one cycle later and does not change on any other cycle, except after a load.
- R3: `sec_strobe` is high for exactly one cycle, in the same cycle that the advanced seconds value first appears on `rd_data`.
- R4: `min_strobe` is high for one cycle together with `sec_strobe`, and only when the seconds field rolls from 0x59 to 0x00.
- R5: A seconds wrap increments the minutes, a minutes wrap at 0x59 increments the hours, and the hours wrap from 0x23 to 0x00, which produces a day carry.
- R6: The weekday field (bit N = day N, with bit 0 = Sunday) rotates left by one bit on each day carry. Bit 6 wraps to bit 0, and bit 7 is kept unchanged.
- R7: On a day carry the day of month returns to 0x01 and the month advances after day 0x30 for months 0x04, 0x06, 0x09 and 0x11, and after day 0x31 for the other months except February.
- R8: February ends after day 0x29 when the year value is divisible by 4, and after day 0x28 otherwise.
- R9: Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R10: When `wr_en` is high, all fields load from `wr_data` at the clock edge and appear on `rd_data` one cycle later. The byte layout in both `wr_data` and `rd_data` is: seconds [7:0], minutes [15:8], hours [23:16], weekday [31:24], day [39:32], month [47:40], year [55:48].
- R11: A load clears the prescaler. A `tb_tick` in the load cycle is ignored and gives no strobe, and the next advance happens on the `TICKS_PER_SEC`-th tick after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | One-cycle timebase pulse from the upstream divider |
| wr_en | input | 1 | Load all seven fields from wr_data |
| wr_data | input | 56 | Packed BCD fields to load |
| rd_data | output | 56 | Packed BCD fields, registered |
| sec_strobe | output | 1 | One-cycle pulse per second advance |
| min_strobe | output | 1 | One-cycle pulse when seconds roll over to 00 |

## Verification
Every result is due exactly one cycle after the edge that causes it. An advance appears on `rd_data` and on the strobes in the cycle after the edge that takes the last prescaled tick, and a load is visible in the cycle after the `wr_en` edge. The bench drives each tick or load for one cycle starting at a falling edge and samples at the next falling edge, after the single register stage. A bench prescaler model sets which tick must give the advance, so every non-final tick is also checked for an unchanged read value and low strobes. The directed cases start one second before each month, year and leap-February boundary, and the random cases start from random valid dates and from states one second before midnight.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } cal_t;

  localparam int CAL_BITS = $bits(cal_t);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m,
                                           input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_wrap_cnt.sv
module bcd_wrap_cnt
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rst_val,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic       inc,
  input  logic [7:0] lo,
  input  logic [7:0] hi,
  output logic [7:0] q,
  output logic       wrap
);

  logic at_top;
  assign at_top = (q >= hi);
  assign wrap   = inc && at_top;

  always_ff @(posedge clk) begin
    if (rst)      q <= rst_val;
    else if (ld)  q <= ld_val;
    else if (inc) q <= at_top ? lo : bcd_inc(q);
  end

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tb_tick,
  output logic sec_pulse
);

  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last   = (cnt == LAST);
  assign sec_pulse = tb_tick && !clr && at_last;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (tb_tick) cnt <= at_last ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [2:0][7:0] ld_val,
  input  logic            sec_pulse,
  output logic [2:0][7:0] q,
  output logic            min_carry,
  output logic            day_carry
);

  // index 0 = seconds, 1 = minutes, 2 = hours
  localparam logic [2:0][7:0] HI = {8'h23, 8'h59, 8'h59};

  logic [3:0] inc;
  logic [2:0] wrap;

  assign inc[0] = sec_pulse;

  for (genvar g = 0; g < 3; g++) begin : g_field
    bcd_wrap_cnt u_cnt (
      .clk     (clk),
      .rst     (rst),
      .rst_val (8'h00),
      .ld      (ld),
      .ld_val  (ld_val[g]),
      .inc     (inc[g]),
      .lo      (8'h00),
      .hi      (HI[g]),
      .q       (q[g]),
      .wrap    (wrap[g])
    );
    assign inc[g+1] = wrap[g];
  end

  assign min_carry = inc[1];
  assign day_carry = inc[3];

endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_day,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic       day_carry,
  output logic [7:0] wday,
  output logic [7:0] day,
  output logic [7:0] month,
  output logic [7:0] year
);

  logic       mon_inc;
  logic       yr_inc;
  logic [7:0] last_day;

  assign last_day = month_len(month, year);

  always_ff @(posedge clk) begin
    if (rst)            wday <= 8'h01;
    else if (ld)        wday <= ld_wday;
    else if (day_carry) wday <= {wday[7], wday[5:0], wday[6]};
  end

  bcd_wrap_cnt u_day (
    .clk (clk), .rst (rst), .rst_val (8'h01), .ld (ld), .ld_val (ld_day),
    .inc (day_carry), .lo (8'h01), .hi (last_day), .q (day), .wrap (mon_inc)
  );

  bcd_wrap_cnt u_month (
    .clk (clk), .rst (rst), .rst_val (8'h01), .ld (ld), .ld_val (ld_month),
    .inc (mon_inc), .lo (8'h01), .hi (8'h12), .q (month), .wrap (yr_inc)
  );

  always_ff @(posedge clk) begin
    if (rst)         year <= 8'h00;
    else if (ld)     year <= ld_year;
    else if (yr_inc) year <= (year >= 8'h99) ? 8'h00 : bcd_inc(year);
  end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tb_tick,
  input  logic                wr_en,
  input  logic [CAL_BITS-1:0] wr_data,
  output logic [CAL_BITS-1:0] rd_data,
  output logic                sec_strobe,
  output logic                min_strobe
);

  cal_t            wv;
  cal_t            cur;
  logic            sec_pulse;
  logic            min_carry;
  logic            day_carry;
  logic [2:0][7:0] tq;

  assign wv = cal_t'(wr_data);

  cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk (clk), .rst (rst), .clr (wr_en), .tb_tick (tb_tick),
    .sec_pulse (sec_pulse)
  );

  cal_time_chain u_time (
    .clk       (clk),
    .rst       (rst),
    .ld        (wr_en),
    .ld_val    ({wv.hour, wv.minute, wv.second}),
    .sec_pulse (sec_pulse),
    .q         (tq),
    .min_carry (min_carry),
    .day_carry (day_carry)
  );

  cal_date_chain u_date (
    .clk       (clk),
    .rst       (rst),
    .ld        (wr_en),
    .ld_wday   (wv.wday),
    .ld_day    (wv.day),
    .ld_month  (wv.month),
    .ld_year   (wv.year),
    .day_carry (day_carry),
    .wday      (cur.wday),
    .day       (cur.day),
    .month     (cur.month),
    .year      (cur.year)
  );

  assign cur.second = tq[0];
  assign cur.minute = tq[1];
  assign cur.hour   = tq[2];
  assign rd_data    = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_strobe <= 1'b0;
      min_strobe <= 1'b0;
    end else begin
      sec_strobe <= sec_pulse;
      min_strobe <= min_carry;
    end
  end

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
  input logic        clk,
  input logic        rst,
  input logic        tb_tick,
  input logic        wr_en,
  input logic [55:0] wr_data,
  input logic [55:0] rd_data,
  input logic        sec_strobe,
  input logic        min_strobe
);

  // R3
  sec_strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    sec_strobe |-> ($past(tb_tick) && !$past(wr_en)));

  // R4
  min_with_sec_chk: assert property (@(posedge clk) disable iff (rst)
    min_strobe |-> (sec_strobe && rd_data[7:0] == 8'h00));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sec_strobe && !$past(wr_en)) |-> $stable(rd_data));

  // R6
  wday_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && rd_data[31:24] != $past(rd_data[31:24])) |->
    (rd_data[31:24] == {$past(rd_data[31]), $past(rd_data[29:24]), $past(rd_data[30])}));

  // R10
  load_visible_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (rd_data == $past(wr_data)));

  // R11
  load_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> !sec_strobe);

endmodule

bind bcd_calendar_clock cal_clock_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tb_tick    (tb_tick),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .sec_strobe (sec_strobe),
  .min_strobe (min_strobe)
);

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;

  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tb_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [55:0] wr_data = '0;
  logic [55:0] rd_data;
  logic        sec_strobe;
  logic        min_strobe;

  int checks = 0;
  int failures = 0;
  int pcnt = 0;
  logic [55:0] model = '0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk (clk), .rst (rst), .tb_tick (tb_tick), .wr_en (wr_en),
    .wr_data (wr_data), .rd_data (rd_data),
    .sec_strobe (sec_strobe), .min_strobe (min_strobe)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] pack(input int s, input int mi, input int h,
                                       input logic [7:0] w, input int d,
                                       input int mo, input int y);
    return {i2b(y), i2b(mo), i2b(d), w, i2b(h), i2b(mi), i2b(s)};
  endfunction

  function automatic logic [55:0] advance(input logic [55:0] st);
    int s, mi, h, d, mo, y;
    logic [7:0] w;
    s = b2i(st[7:0]); mi = b2i(st[15:8]); h = b2i(st[23:16]);
    w = st[31:24]; d = b2i(st[39:32]); mo = b2i(st[47:40]); y = b2i(st[55:48]);
    s++;
    if (s == 60) begin s = 0; mi++; end
    if (mi == 60) begin mi = 0; h++; end
    if (h == 24) begin
      h = 0;
      w = {w[7], w[5:0], w[6]};
      d++;
      if (d > mdays(mo, y)) begin d = 1; mo++; end
      if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
    end
    return pack(s, mi, h, w, d, mo, y);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one timebase pulse; checks result after the single register stage
  task automatic tick_once(input string tag);
    logic es, em;
    @(negedge clk) tb_tick = 1'b1;
    @(negedge clk) tb_tick = 1'b0;
    es = 1'b0; em = 1'b0;
    pcnt++;
    if (pcnt == TPS) begin
      pcnt = 0;
      es = 1'b1;
      em = (model[7:0] == 8'h59);
      model = advance(model);
    end
    chk("R3", 64'(sec_strobe), 64'(es));
    chk("R4", 64'(min_strobe), 64'(em));
    chk(tag, 64'(rd_data), 64'(model));
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic one_second(input string tag);
    for (int i = pcnt; i < TPS; i++) tick_once(tag);
  endtask

  task automatic load(input logic [55:0] v, input logic with_tick);
    @(negedge clk) begin wr_en = 1'b1; wr_data = v; tb_tick = with_tick; end
    @(negedge clk) begin wr_en = 1'b0; tb_tick = 1'b0; end
    model = v; pcnt = 0;
    chk("R10", 64'(rd_data), 64'(v));
    chk("R11", 64'(sec_strobe), 64'd0);
  endtask

  function automatic logic [55:0] rand_state(input logic near_midnight);
    int mo, y;
    mo = 1 + $urandom % 12; y = $urandom % 100;
    if (near_midnight)
      return pack(59, 59, 23, 8'(1 << ($urandom % 7)), 1 + $urandom % mdays(mo, y), mo, y);
    return pack($urandom % 60, $urandom % 60, $urandom % 24, 8'(1 << ($urandom % 7)),
                1 + $urandom % mdays(mo, y), mo, y);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 64'(rd_data), 64'(56'h00_01_01_01_00_00_00));
    chk("R1", 64'({sec_strobe, min_strobe}), 64'd0);
    model = 56'h00_01_01_01_00_00_00;

    repeat (3) one_second("R2");

    // R11: tick in the load cycle ignored, next advance after TPS ticks
    load(pack(58, 59, 22, 8'h08, 15, 6, 20), 1'b1);
    one_second("R11");
    one_second("R4");
    one_second("R5");
    // R8: leap February 29 -> March 1, weekday 0x02 -> 0x04
    load(pack(59, 59, 23, 8'h02, 29, 2, 16), 1'b0);
    one_second("R8");
    chk("R6", 64'(rd_data[31:24]), 64'h04);
    // R8: Feb 28 in a leap year goes to Feb 29
    load(pack(59, 59, 23, 8'h01, 28, 2, 24), 1'b0);
    one_second("R8");
    chk("R8", 64'(rd_data[47:32]), 64'h0229);
    // R8: Feb 28 in a common year goes to March 1
    load(pack(59, 59, 23, 8'h01, 28, 2, 17), 1'b0);
    one_second("R8");
    chk("R8", 64'(rd_data[47:32]), 64'h0301);
    // R7: 30-day and 31-day month ends
    load(pack(59, 59, 23, 8'h10, 30, 4, 21), 1'b0);
    one_second("R7");
    chk("R7", 64'(rd_data[47:32]), 64'h0501);
    load(pack(59, 59, 23, 8'h10, 30, 1, 21), 1'b0);
    one_second("R7");
    chk("R7", 64'(rd_data[47:32]), 64'h0131);
    // R9 and R6: year 99 -> 00, weekday bit 6 wraps to bit 0
    load(pack(59, 59, 23, 8'h40, 31, 12, 99), 1'b0);
    one_second("R9");
    chk("R9", 64'(rd_data[55:32]), 64'h000101);
    chk("R6", 64'(rd_data[31:24]), 64'h01);
    chk("R5", 64'(rd_data[23:0]), 64'h000000);

    for (int n = 0; n < 60; n++) begin
      load(rand_state(n[0]), 1'($urandom % 2));
      repeat (1 + $urandom % 3) one_second(n[0] ? "R5" : "R2");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule